// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts conditional branches from two sources together. The first is the global outcome history, which records the last few branches resolved anywhere in the program. The second is the low bits of the branch's own address. The address bits pick a row of saturating counters, and the history register picks one counter inside that row. A fetch stage presents a lookup address. One cycle later it receives the predicted direction and the history value that was used.

When the branch resolves, the back end returns the branch address, the actual outcome and the history value it got with the prediction. The block moves the counter chosen by that address and history one step toward the outcome. It also shifts the outcome into the global history. Because the returned history is used for training, the counter that gets trained is the one that made the prediction, even when other branches have resolved in the meantime.

The counters are in a plain synchronous memory with no reset, so the memory can be mapped onto block RAM. A vector of written flags, one per counter, makes every counter that has never been trained read back as weakly-not-taken.

Top module: `corr_bp_predictor`

## Requirements
- R1: After reset the history register holds all zeros, and every counter reads as weakly-not-taken (2^(N-1)-1), so every lookup predicts not taken.
- R2: `pred_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high, and low otherwise.
- R3: `pred_taken` is 1 exactly when the selected counter is at least 2^(N-1), that is, when its most significant bit is set.
- R4: A training update moves the counter one step toward the outcome and saturates at 0 and at 2^N-1, with no wrap-around.
- R5: Each accepted update shifts its outcome into bit 0 of the history register, moves the older bits up one place and drops the oldest. `pred_hist` returns the history used for the lookup, with bit 0 as the most recent outcome (1 = taken).
- R6: The counter row is chosen by address bits [ADDR_LSB+ROW_BITS-1:ADDR_LSB] only. Address bits outside that field do not change the prediction.
- R7: Within a row, the history value chooses the counter. Training one history value leaves the counters of the other history values in that row unchanged.
- R8: An update trains the counter chosen by `up_hist` and its own row, not the counter chosen by the current history register.
- R9: A lookup in the same cycle as an update sees the history and counter values from before that update.
- R10: An update takes effect for lookups and updates accepted from the following cycle onward. This includes back-to-back updates to the same counter, each of which counts.
- R11: While `up_valid` is low, `up_addr`, `up_hist` and `up_taken` have no effect on the history or on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address of the branch being fetched |
| pred_valid | output | 1 | Prediction available (one cycle after lookup) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_BITS | History value used for this prediction |
| up_valid | input | 1 | Resolved-branch update request |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_hist | input | HIST_BITS | History returned with the prediction for this branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong history register can be seen at once: the next lookup returns it on `pred_hist`, so a bad shift or a missed shift appears one cycle after the lookup that follows it. A wrong counter only shows as a flipped `pred_taken`, and only when the error moves the value across the half-range threshold. For that reason the stimulus drives counters to both saturation limits and steps back once, and it looks up a counter in the cycle right after an update to it. This is where a missing write-through path would return a stale value one cycle after the update. An update that trains the wrong counter shows only when a later lookup reaches that counter, after the history has been steered to the matching value.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  // Largest value of an n-bit saturating counter.
  function automatic int unsigned ctr_max(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Weakly-not-taken: one below the half-range threshold.
  function automatic int unsigned ctr_weak_nt(input int unsigned n);
    return (32'd1 << (n - 32'd1)) - 32'd1;
  endfunction

  // One saturating step toward the resolved outcome.
  function automatic int unsigned ctr_next(input int unsigned cnt,
                                           input logic        taken,
                                           input int unsigned n);
    if (taken)
      return (cnt >= ctr_max(n)) ? ctr_max(n) : cnt + 32'd1;
    else
      return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction

endpackage

// File: rtl/corr_bp_history.sv
module corr_bp_history #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [M-1:0] hist_o
);

  logic [M-1:0] hist_q;

  // Newest outcome enters at bit 0, oldest leaves at bit M-1.
  generate
    if (M == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= shift_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[M-2:0], shift_in};
      end
    end
  endgenerate

  assign hist_o = hist_q;

endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table #(
  parameter int IDX_W = 6,
  parameter int N     = 2,
  parameter int PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PORTS-1:0]            rd_en,
  input  logic [PORTS-1:0][IDX_W-1:0] rd_idx,
  output logic [PORTS-1:0][N-1:0]     rd_cnt,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [N-1:0]                wr_cnt
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [N-1:0] WEAK_NT = N'(corr_bp_pkg::ctr_weak_nt(N));

  // Counter storage: no reset, so it can map to block RAM.
  logic [N-1:0]     mem [DEPTH];
  // One flag per counter: set once the counter has been written.
  logic [DEPTH-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)        seen_q <= '0;
    else if (wr_en) seen_q[wr_idx] <= 1'b1;
  end

  // Synchronous read ports, each with write-through forwarding.
  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_rd
      logic [N-1:0] ram_q;
      logic         seen_rd_q;
      logic         fwd_q;
      logic [N-1:0] fwd_val_q;

      always_ff @(posedge clk) begin
        if (rd_en[p]) ram_q <= mem[rd_idx[p]];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          seen_rd_q <= 1'b0;
          fwd_q     <= 1'b0;
          fwd_val_q <= '0;
        end else if (rd_en[p]) begin
          seen_rd_q <= seen_q[rd_idx[p]];
          fwd_q     <= wr_en && (wr_idx == rd_idx[p]);
          fwd_val_q <= wr_cnt;
        end
      end

      assign rd_cnt[p] = fwd_q     ? fwd_val_q :
                         seen_rd_q ? ram_q     : WEAK_NT;
    end
  endgenerate

endmodule

// File: rtl/corr_bp_train.sv
module corr_bp_train #(
  parameter int IDX_W = 6,
  parameter int N     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  input  logic [N-1:0]     cur_cnt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [N-1:0]     wr_cnt,
  output logic             wr_taken
);

  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic             taken_q;

  // Stage 1 captures the request while the table reads the counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      idx_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      pend_q <= up_valid;
      if (up_valid) begin
        idx_q   <= up_idx;
        taken_q <= up_taken;
      end
    end
  end

  // Stage 2 steps the counter and writes it back.
  assign wr_en    = pend_q;
  assign wr_idx   = idx_q;
  assign wr_taken = taken_q;
  assign wr_cnt   = N'(corr_bp_pkg::ctr_next(32'(cur_cnt), taken_q, N));

endmodule

// File: rtl/corr_bp_predictor.sv
module corr_bp_predictor #(
  parameter int ADDR_W    = 32,
  parameter int ADDR_LSB  = 2,
  parameter int ROW_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 pred_valid,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 up_valid,
  input  logic [ADDR_W-1:0]    up_addr,
  input  logic [HIST_BITS-1:0] up_hist,
  input  logic                 up_taken
);

  localparam int IDX_W = ROW_BITS + HIST_BITS;
  localparam int P_LK  = 0;
  localparam int P_UP  = 1;

  logic [HIST_BITS-1:0]    hist_w;
  logic [IDX_W-1:0]        lk_idx;
  logic [IDX_W-1:0]        up_idx;
  logic [1:0]              rd_en;
  logic [1:0][IDX_W-1:0]   rd_idx;
  logic [1:0][CTR_BITS-1:0] rd_cnt;
  logic                    wr_en_w;
  logic [IDX_W-1:0]        wr_idx_w;
  logic [CTR_BITS-1:0]     wr_cnt_w;
  logic                    wr_taken_w;
  logic                    pred_valid_q;
  logic [HIST_BITS-1:0]    pred_hist_q;
  logic                    unused_addr_bits;

  assign unused_addr_bits = ^{lk_addr, up_addr};

  // Row from the address field, column from the history.
  assign lk_idx = {lk_addr[ADDR_LSB +: ROW_BITS], hist_w};
  assign up_idx = {up_addr[ADDR_LSB +: ROW_BITS], up_hist};

  assign rd_en[P_LK]  = lk_valid;
  assign rd_idx[P_LK] = lk_idx;
  assign rd_en[P_UP]  = up_valid;
  assign rd_idx[P_UP] = up_idx;

  corr_bp_history #(.M(HIST_BITS)) u_history (
    .clk      (clk),
    .rst      (rst),
    .shift_en (up_valid),
    .shift_in (up_taken),
    .hist_o   (hist_w)
  );

  corr_bp_table #(.IDX_W(IDX_W), .N(CTR_BITS), .PORTS(2)) u_table (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_cnt (rd_cnt),
    .wr_en  (wr_en_w),
    .wr_idx (wr_idx_w),
    .wr_cnt (wr_cnt_w)
  );

  corr_bp_train #(.IDX_W(IDX_W), .N(CTR_BITS)) u_train (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_idx   (up_idx),
    .up_taken (up_taken),
    .cur_cnt  (rd_cnt[P_UP]),
    .wr_en    (wr_en_w),
    .wr_idx   (wr_idx_w),
    .wr_cnt   (wr_cnt_w),
    .wr_taken (wr_taken_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid_q <= 1'b0;
      pred_hist_q  <= '0;
    end else begin
      pred_valid_q <= lk_valid;
      if (lk_valid) pred_hist_q <= hist_w;
    end
  end

  assign pred_valid = pred_valid_q;
  assign pred_hist  = pred_hist_q;
  assign pred_taken = rd_cnt[P_LK][CTR_BITS-1];

endmodule

// File: rtl/corr_bp_checker.sv
module corr_bp_checker #(
  parameter int M = 2,
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic         pred_valid,
  input logic [M-1:0] pred_hist,
  input logic         up_valid,
  input logic         up_taken,
  input logic [M-1:0] hist_q,
  input logic         wr_en,
  input logic         wr_taken,
  input logic [N-1:0] wr_cnt,
  input logic [N-1:0] cur_cnt
);

  assert_reset_hist_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> hist_q == '0);

  assert_pred_follows_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);

  assert_no_stray_pred_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);

  assert_ctr_rises_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |-> wr_cnt >= cur_cnt);

  assert_ctr_falls_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken) |-> wr_cnt <= cur_cnt);

  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> hist_q[0] == $past(up_taken));

  assert_pred_hist_old_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_hist == $past(hist_q));

  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(hist_q));

endmodule

bind corr_bp_predictor corr_bp_checker #(.M(HIST_BITS), .N(CTR_BITS)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .pred_valid (pred_valid),
  .pred_hist  (pred_hist),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .hist_q     (hist_w),
  .wr_en      (wr_en_w),
  .wr_taken   (wr_taken_w),
  .wr_cnt     (wr_cnt_w),
  .cur_cnt    (rd_cnt[1])
);

// File: tb/corr_bp_predictor_tb.sv
`timescale 1ns/1ps
module corr_bp_predictor_tb;

  localparam int AW   = 8;
  localparam int LSB  = 2;
  localparam int RB   = 2;
  localparam int HB   = 2;
  localparam int CB   = 2;
  localparam int HN   = 1 << HB;
  localparam int ROWS = 1 << RB;
  localparam int CMAX = (1 << CB) - 1;
  localparam int HALF = 1 << (CB - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          pred_valid;
  logic          pred_taken;
  logic [HB-1:0] pred_hist;
  logic          up_valid = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [HB-1:0] up_hist = '0;
  logic          up_taken = 1'b0;

  always #2.5 clk = ~clk;

  corr_bp_predictor #(
    .ADDR_W(AW), .ADDR_LSB(LSB), .ROW_BITS(RB), .HIST_BITS(HB), .CTR_BITS(CB)
  ) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .up_valid(up_valid), .up_addr(up_addr), .up_hist(up_hist), .up_taken(up_taken)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model
  int    mcnt [ROWS*HN];
  int    mhist;
  bit    exp_pv;
  int    exp_pt;
  int    exp_ph;
  string exp_tag;
  bit    prev_uv;
  int    prev_uidx;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic int row_of(input logic [AW-1:0] a);
    return (int'(a) >> LSB) & (ROWS - 1);
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit lv, input logic [AW-1:0] la,
                      input bit uv, input logic [AW-1:0] ua,
                      input int uh, input bit ut, input string tag);
    int lidx;
    int uidx;
    @(negedge clk);
    // results of the previous cycle's lookup
    chk(int'(pred_valid), int'(exp_pv), "R2");
    if (exp_pv) begin
      chk(int'(pred_taken), exp_pt, exp_tag);
      chk(int'(pred_hist), exp_ph, "R5");
    end
    lk_valid = lv;
    lk_addr  = la;
    up_valid = uv;
    up_addr  = ua;
    up_hist  = HB'(uh);
    up_taken = ut;
    exp_pv = lv;
    if (lv) begin
      lidx    = row_of(la) * HN + mhist;
      exp_pt  = (mcnt[lidx] >= HALF) ? 1 : 0;
      exp_ph  = mhist;
      if (tag != "")                         exp_tag = tag;
      else if (uv)                           exp_tag = "R9";
      else if (prev_uv && prev_uidx == lidx) exp_tag = "R10";
      else                                   exp_tag = "R3";
    end
    prev_uv = uv;
    if (uv) begin
      uidx = row_of(ua) * HN + (uh & (HN - 1));
      if (ut) mcnt[uidx] = (mcnt[uidx] >= CMAX) ? CMAX : mcnt[uidx] + 1;
      else    mcnt[uidx] = (mcnt[uidx] == 0) ? 0 : mcnt[uidx] - 1;
      mhist = ((mhist << 1) | int'(ut)) & (HN - 1);
      prev_uidx = uidx;
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: got=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ROWS*HN; i++) mcnt[i] = HALF - 1;
    mhist = 0; exp_pv = 0; exp_pt = 0; exp_ph = 0; exp_tag = "R3";
    prev_uv = 0; prev_uidx = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: every row predicts not taken with a zero history after reset
    for (int r = 0; r < ROWS; r++) step(1, AW'(r << LSB), 0, '0, 0, 0, "R1");

    // R4 upper saturation: four takens on (row1,h2), then one not-taken
    for (int k = 0; k < 4; k++) step(0, '0, 1, 8'h04, 2, 1, "");
    step(0, '0, 1, 8'h04, 2, 0, "");
    step(1, 8'h04, 0, '0, 0, 0, "R4");
    // R6: upper address bits differ, same row field
    step(1, 8'hF4, 0, '0, 0, 0, "R6");
    step(1, 8'h34, 0, '0, 0, 0, "R6");

    // R7: same row, another history value stays untrained
    step(0, '0, 1, 8'h08, 0, 1, "");
    step(1, 8'h04, 0, '0, 0, 0, "R7");

    // R4 lower saturation: four not-takens on (row2,h1), then one taken
    for (int k = 0; k < 4; k++) step(0, '0, 1, 8'h08, 1, 0, "");
    step(0, '0, 1, 8'h08, 1, 1, "");
    step(1, 8'h08, 0, '0, 0, 0, "R4");

    // R8: train (row3,h0) while the live history is nonzero
    step(0, '0, 1, 8'h0C, 0, 1, "");
    step(0, '0, 1, 8'h0C, 0, 1, "");
    step(0, '0, 1, 8'h00, 3, 0, "");
    step(0, '0, 1, 8'h00, 3, 0, "");
    step(1, 8'h0C, 0, '0, 0, 0, "R8");

    // R9/R10: same-cycle lookup sees old state, next cycle sees new
    step(1, 8'h0C, 1, 8'h0C, 0, 0, "R9");
    step(1, 8'h0C, 0, '0, 0, 0, "R10");
    step(0, '0, 1, 8'h0C, 0, 0, "");
    step(1, 8'h0C, 0, '0, 0, 0, "R10");

    // R11: junk on the update port with up_valid low
    for (int k = 0; k < 3; k++) step(0, '0, 0, 8'hFF, 3, 1, "");
    step(1, 8'h0C, 0, '0, 0, 0, "R11");
    step(1, 8'h04, 0, '0, 0, 0, "R11");

    // Near-exhaustive mixed traffic over every row and history value
    for (int i = 0; i < 6000; i++) begin
      logic [AW-1:0] la;
      logic [AW-1:0] ua;
      int  uh;
      bit  ut;
      lfsr = lfsr_next(lfsr);
      lfsr = lfsr_next(lfsr);
      la = lfsr[15:8];
      ua = lfsr[4] ? la : lfsr[23:16];
      uh = lfsr[5] ? mhist : int'(lfsr[25:24]);
      ut = (row_of(ua) % 2 == 1) ? (lfsr[30:28] != 3'd0) : (lfsr[30:28] == 3'd0);
      step(lfsr[0] | lfsr[1], la, lfsr[2] | lfsr[3], ua, uh, ut, "");
    end
    step(0, '0, 0, '0, 0, 0, "");
    step(0, '0, 0, '0, 0, 0, "");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule